// File: doc/BRIEF.md
# Nibble-Serial Register Command Decoder

This block sits behind a byte-wide host link and turns a stream of small command bytes into accesses on a tiny internal register file. Every command byte holds a 4-bit opcode in its upper half and a 4-bit payload in its lower half. Two opcodes build an 8-bit register address, one nibble at a time. Two more build a write value, and the second of these also commits the write. Read opcodes push one response byte into an outgoing stream. One of the read opcodes also steps the address forward, so a run of such reads walks through consecutive registers.

The address latch and the low data nibble latch hold their values from one command to the next. A host can therefore send only the nibble that changes. It can also pack many writes and reads into one burst and collect the replies in order.

The register file holds:
- a fixed identification byte;
- a scratch byte for link testing;
- a mode byte that is driven out of the block;
- a read-only status byte;
- a six-byte read-only block with two 24-bit positions, each read least significant byte first.

Top module: `nibreg_cmd_decoder`

## Requirements
- R1: The opcode is `cmd_data[7:4]` and the payload is `cmd_data[3:0]`. The opcodes are: 0x0 set address low nibble, 0x1 set address high nibble, 0x2 latch data low nibble, 0x3 data high nibble with write, 0x4 read, 0x5 read then increment. Opcodes 0x6 to 0xF are accepted and change nothing: no response, no change to the address or the mode.
- R2: Opcode 0x0 loads address bits 3:0 and keeps bits 7:4. Opcode 0x1 loads address bits 7:4 and keeps bits 3:0.
- R3: Opcode 0x2 stores the payload as the pending low nibble. Opcode 0x3 writes `{payload, pending low nibble}` to the current address in the same accepted cycle. The pending nibble persists across commands.
- R4: A read (0x4 or 0x5) pushes exactly one byte, the current content of the addressed register. Opcode 0x5 then adds one to the address, wrapping from 0xFF to 0x00.
- R5: Address 0x00 always reads 0xA6, and writes to it have no effect.
- R6: Address 0x01 is a scratch byte that reads back the last value written, for example 0x55 and then 0xAA.
- R7: Address 0x02 is the mode byte. It is read/write and appears on `mode_out` from the cycle after the write. It changes on no other command.
- R8: Address 0x03 reads `status_in`. Addresses 0x10 to 0x12 read `trig_pos` bytes 0, 1, 2 and addresses 0x13 to 0x15 read `stop_pos` bytes 0, 1, 2. Writes to these addresses have no effect. Every other address reads 0x00.
- R9: Responses leave in the same order as the read commands, through a queue of RSP_DEPTH entries. `cmd_ready` is low while the queue is full. `rsp_data` stays unchanged while `rsp_valid` is high and `rsp_ready` is low.
- R10: After reset the address, the pending nibble and the mode are 0x00. The response queue is empty and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte accepted this cycle when valid |
| cmd_data | input | 8 | Command byte: opcode 7:4, payload 3:0 |
| rsp_valid | output | 1 | Response byte available |
| rsp_ready | input | 1 | Downstream takes the response byte |
| rsp_data | output | 8 | Response byte |
| status_in | input | 8 | Live status byte shown at address 0x03 |
| trig_pos | input | 24 | First position value, read at 0x10 to 0x12 |
| stop_pos | input | 24 | Second position value, read at 0x13 to 0x15 |
| mode_out | output | 8 | Current mode register |

## Verification
A wrong address latch cannot be seen until the next read, and it then returns a byte from the wrong register. The bench therefore follows every address-changing pattern with reads: a single nibble update, a run of incrementing reads, and a wrap at 0xFF. A lost or duplicated queue entry shows up as a reply out of order or as an extra reply some cycles later. For this reason every reply is compared against an ordered list of expected values while the downstream ready is throttled at random. A wrongly committed write is caught either on `mode_out` in the very next cycle or when the affected register is next read.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
   localparam int NIB_W  = 4;
   localparam int BYTE_W = 2 * NIB_W;

   typedef enum logic [NIB_W-1:0] {
      OP_ADDR_LO = 4'h0,
      OP_ADDR_HI = 4'h1,
      OP_DATA_LO = 4'h2,
      OP_DATA_WR = 4'h3,
      OP_READ    = 4'h4,
      OP_READ_INC = 4'h5
   } nrd_op_e;

   function automatic logic op_is_read(input logic [NIB_W-1:0] op);
      return (op == OP_READ) || (op == OP_READ_INC);
   endfunction
endpackage

// File: rtl/nrd_parser.sv
module nrd_parser
   import nrd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [BYTE_W-1:0] cmd_byte,
   output logic [BYTE_W-1:0] addr_q,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_data,
   output logic              rd_en
);
   logic [NIB_W-1:0] op;
   logic [NIB_W-1:0] nib;
   logic [NIB_W-1:0] lo_q;

   assign op  = cmd_byte[BYTE_W-1:NIB_W];
   assign nib = cmd_byte[NIB_W-1:0];

   assign wr_en   = accept && (op == OP_DATA_WR);
   assign wr_data = {nib, lo_q};
   assign rd_en   = accept && op_is_read(op);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         lo_q   <= '0;
      end else if (accept) begin
         case (op)
            OP_ADDR_LO:  addr_q[NIB_W-1:0]      <= nib;
            OP_ADDR_HI:  addr_q[BYTE_W-1:NIB_W] <= nib;
            OP_DATA_LO:  lo_q                   <= nib;
            OP_READ_INC: addr_q                 <= addr_q + BYTE_W'(1);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/nrd_regfile.sv
module nrd_regfile
   import nrd_pkg::*;
#(
   parameter logic [BYTE_W-1:0] ID_VALUE     = 8'hA6,
   parameter logic [BYTE_W-1:0] ID_ADDR      = 8'h00,
   parameter logic [BYTE_W-1:0] SCRATCH_ADDR = 8'h01,
   parameter logic [BYTE_W-1:0] MODE_ADDR    = 8'h02,
   parameter logic [BYTE_W-1:0] STATUS_ADDR  = 8'h03,
   parameter logic [BYTE_W-1:0] POS_BASE     = 8'h10,
   parameter int                POS_W        = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [BYTE_W-1:0] status_in,
   input  logic [POS_W-1:0]  trig_pos,
   input  logic [POS_W-1:0]  stop_pos,
   output logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] mode_q
);
   localparam int HALF      = POS_W / BYTE_W;
   localparam int POS_BYTES = 2 * HALF;

   logic [BYTE_W-1:0] scratch_q;
   logic [BYTE_W-1:0] pos_b [POS_BYTES];

   if (POS_W % BYTE_W != 0) begin : g_bad_pos
      $error("POS_W must be a whole number of bytes");
   end

   for (genvar i = 0; i < POS_BYTES; i++) begin : g_pos
      if (i < HALF) begin : g_trig
         assign pos_b[i] = trig_pos[BYTE_W*i +: BYTE_W];
      end else begin : g_stop
         assign pos_b[i] = stop_pos[BYTE_W*(i-HALF) +: BYTE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scratch_q <= '0;
         mode_q    <= '0;
      end else if (wr_en) begin
         if (addr == SCRATCH_ADDR) scratch_q <= wr_data;
         if (addr == MODE_ADDR)    mode_q    <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (addr == ID_ADDR)           rd_data = ID_VALUE;
      else if (addr == SCRATCH_ADDR) rd_data = scratch_q;
      else if (addr == MODE_ADDR)    rd_data = mode_q;
      else if (addr == STATUS_ADDR)  rd_data = status_in;
      else begin
         for (int i = 0; i < POS_BYTES; i++) begin
            if (addr == POS_BASE + i[BYTE_W-1:0]) rd_data = pos_b[i];
         end
      end
   end
endmodule

// File: rtl/nrd_rsp_fifo.sv
module nrd_rsp_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          nonempty,
   output logic          full,
   output logic [CW-1:0] cnt
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic         v_q;
      logic [W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) v_q <= 1'b0;
         else if (push) v_q <= 1'b1;
         else if (pop) v_q <= 1'b0;
      end
      always_ff @(posedge clk) begin
         if (push) d_q <= push_data;
      end
      assign head = d_q;
      assign cnt  = CW'(v_q);
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      if ((1 << PW) != DEPTH) begin : g_bad_pow2
         $error("DEPTH above 1 must be a power of two");
      end
      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] wp, rp;
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            cnt_q <= '0;
         end else begin
            if (push) wp <= wp + PW'(1);
            if (pop)  rp <= rp + PW'(1);
            if (push && !pop)      cnt_q <= cnt_q + CW'(1);
            else if (pop && !push) cnt_q <= cnt_q - CW'(1);
         end
      end
      always_ff @(posedge clk) begin
         if (push) mem[wp] <= push_data;
      end
      assign head = mem[rp];
      assign cnt  = cnt_q;
   end

   assign nonempty = (cnt != '0);
   assign full     = (cnt == CW'(DEPTH));
endmodule

// File: rtl/nibreg_cmd_decoder.sv
module nibreg_cmd_decoder
   import nrd_pkg::*;
#(
   parameter int                RSP_DEPTH = 4,
   parameter logic [BYTE_W-1:0] ID_VALUE  = 8'hA6,
   parameter logic [BYTE_W-1:0] POS_BASE  = 8'h10,
   parameter int                POS_W     = 24,
   localparam int               CNT_W     = $clog2(RSP_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [BYTE_W-1:0] cmd_data,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [BYTE_W-1:0] rsp_data,
   input  logic [BYTE_W-1:0] status_in,
   input  logic [POS_W-1:0]  trig_pos,
   input  logic [POS_W-1:0]  stop_pos,
   output logic [BYTE_W-1:0] mode_out
);
   logic              accept;
   logic              pop;
   logic              full;
   logic              wr_en;
   logic              rd_en;
   logic [BYTE_W-1:0] addr_q;
   logic [BYTE_W-1:0] wr_data;
   logic [BYTE_W-1:0] rd_data;
   logic [CNT_W-1:0]  rsp_cnt;

   assign cmd_ready = !full;
   assign accept    = cmd_valid && cmd_ready;
   assign pop       = rsp_valid && rsp_ready;

   nrd_parser u_parser (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .cmd_byte (cmd_data),
      .addr_q   (addr_q),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_en    (rd_en)
   );

   nrd_regfile #(
      .ID_VALUE (ID_VALUE),
      .POS_BASE (POS_BASE),
      .POS_W    (POS_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr_q),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .status_in (status_in),
      .trig_pos  (trig_pos),
      .stop_pos  (stop_pos),
      .rd_data   (rd_data),
      .mode_q    (mode_out)
   );

   nrd_rsp_fifo #(
      .DEPTH (RSP_DEPTH),
      .W     (BYTE_W)
   ) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rd_en),
      .push_data (rd_data),
      .pop       (pop),
      .head      (rsp_data),
      .nonempty  (rsp_valid),
      .full      (full),
      .cnt       (rsp_cnt)
   );
endmodule

// File: rtl/nrd_checker.sv
module nrd_checker
   import nrd_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int CNT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [BYTE_W-1:0] cmd_data,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [BYTE_W-1:0] rsp_data,
   input logic [BYTE_W-1:0] mode_out,
   input logic [BYTE_W-1:0] addr_q,
   input logic [CNT_W-1:0]  rsp_cnt
);
   logic             acc, pop_c, unk;
   logic [NIB_W-1:0] op;

   assign op    = cmd_data[BYTE_W-1:NIB_W];
   assign acc   = cmd_valid && cmd_ready;
   assign pop_c = rsp_valid && rsp_ready;
   assign unk   = (op > OP_READ_INC);

   // R2
   addr_low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op == OP_ADDR_LO |=> addr_q == {$past(addr_q[BYTE_W-1:NIB_W]), $past(cmd_data[NIB_W-1:0])});

   // R2
   addr_high_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op == OP_ADDR_HI |=> addr_q == {$past(cmd_data[NIB_W-1:0]), $past(addr_q[NIB_W-1:0])});

   // R4
   read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op == OP_READ_INC |=> addr_q == $past(addr_q) + BYTE_W'(1));

   // R4
   read_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_is_read(op) && !pop_c |=> rsp_cnt == $past(rsp_cnt) + CNT_W'(1));

   // R1
   unknown_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && unk && !pop_c |=> $stable(rsp_cnt) && $stable(addr_q) && $stable(mode_out));

   // R7
   mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && op == OP_DATA_WR) |=> $stable(mode_out));

   // R9
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_cnt == CNT_W'(DEPTH) |-> !cmd_ready);
endmodule

bind nibreg_cmd_decoder nrd_checker #(
   .DEPTH (RSP_DEPTH),
   .CNT_W (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_data  (cmd_data),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .rsp_data  (rsp_data),
   .mode_out  (mode_out),
   .addr_q    (addr_q),
   .rsp_cnt   (rsp_cnt)
);

// File: tb/sim_nibreg_cmd_decoder.sv
module sim_nibreg_cmd_decoder;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [7:0]  cmd_data = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [7:0]  rsp_data;
   logic [7:0]  status_in = 8'h00;
   logic [23:0] trig_pos = '0;
   logic [23:0] stop_pos = '0;
   logic [7:0]  mode_out;

   int checks = 0;
   int fails  = 0;
   bit hold   = 1'b0;
   bit rnd_rdy = 1'b0;

   logic [7:0] m_addr = '0, m_scr = '0, m_mode = '0;
   logic [3:0] m_lo = '0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #4 clk = ~clk;

   nibreg_cmd_decoder #(.RSP_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_data(rsp_data), .status_in(status_in), .trig_pos(trig_pos),
      .stop_pos(stop_pos), .mode_out(mode_out)
   );

   function automatic logic [7:0] model_read(input logic [7:0] a);
      case (a)
         8'h00: return 8'hA6;
         8'h01: return m_scr;
         8'h02: return m_mode;
         8'h03: return status_in;
         8'h10: return trig_pos[7:0];
         8'h11: return trig_pos[15:8];
         8'h12: return trig_pos[23:16];
         8'h13: return stop_pos[7:0];
         8'h14: return stop_pos[15:8];
         8'h15: return stop_pos[23:16];
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model(input logic [3:0] op, input logic [3:0] nib, input string tag);
      case (op)
         4'h0: m_addr[3:0] = nib;
         4'h1: m_addr[7:4] = nib;
         4'h2: m_lo = nib;
         4'h3: begin
            if (m_addr == 8'h01) m_scr = {nib, m_lo};
            if (m_addr == 8'h02) m_mode = {nib, m_lo};
         end
         4'h4, 4'h5: begin
            exp_q.push_back(model_read(m_addr));
            tag_q.push_back(tag);
            if (op == 4'h5) m_addr = m_addr + 8'd1;
         end
         default: ;
      endcase
   endtask

   task automatic send(input logic [3:0] op, input logic [3:0] nib, input string tag);
      bit acc;
      cmd_valid = 1'b1;
      cmd_data  = {op, nib};
      do begin
         acc = cmd_ready;
         if (acc) model(op, nib, tag);
         @(posedge clk);
         @(negedge clk);
      end while (!acc);
      cmd_valid = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 300; i++) begin
         if (exp_q.size() == 0 && !rsp_valid) break;
         @(negedge clk);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // response monitor: picks ready, compares every byte that will be taken
   always @(negedge clk) begin
      bit r;
      if (rst_n) begin
         r = hold ? 1'b0 : (rnd_rdy ? ($urandom % 4 != 0) : 1'b1);
         rsp_ready = r;
         if (rsp_valid && r) begin
            if (exp_q.size() == 0) begin
               check("R9 unexpected response", rsp_data, 8'hxx);
            end else begin
               check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 rsp_valid", {7'd0, rsp_valid}, 8'h00);
      check("R10 cmd_ready", {7'd0, cmd_ready}, 8'h01);
      check("R10 mode_out", mode_out, 8'h00);
      send(4'h4, 4'h0, "R10 address zero after reset");

      // R5 identity, write ignored
      send(4'h0, 4'h0, ""); send(4'h1, 4'h0, "");
      send(4'h4, 4'h0, "R5 id read");
      send(4'h2, 4'h3, ""); send(4'h3, 4'h3, "");
      send(4'h4, 4'h0, "R5 id after write");

      // R6 scratch, R3 write assembly
      send(4'h0, 4'h1, "");
      send(4'h2, 4'h5, ""); send(4'h3, 4'h5, "");
      send(4'h4, 4'h0, "R6 scratch 55");
      send(4'h2, 4'hA, ""); send(4'h3, 4'hA, "");
      send(4'h4, 4'h0, "R6 scratch AA");
      send(4'h3, 4'h1, "");
      send(4'h4, 4'h0, "R3 low nibble kept");

      // R7 mode register
      send(4'h0, 4'h2, "");
      send(4'h2, 4'hC, ""); send(4'h3, 4'h3, "");
      check("R7 mode_out", mode_out, 8'h3C);
      send(4'h4, 4'h0, "R7 mode read");

      // R8 / R4 position walk
      drain();
      trig_pos = 24'h123456; stop_pos = 24'hABCDEF; status_in = 8'h9D;
      send(4'h1, 4'h1, ""); send(4'h0, 4'h0, "");
      for (int i = 0; i < 6; i++) send(4'h5, 4'h0, "R8 position byte via R4 increment");
      send(4'h0, 4'h3, "");
      send(4'h4, 4'h0, "R2 high nibble kept");
      send(4'h1, 4'h0, "");
      send(4'h4, 4'h0, "R8 status");
      send(4'h2, 4'h0, ""); send(4'h3, 4'h0, "");
      send(4'h4, 4'h0, "R8 status write ignored");
      send(4'h1, 4'h4, ""); send(4'h0, 4'h4, "");
      send(4'h4, 4'h0, "R8 unmapped zero");

      // R4 wrap
      send(4'h1, 4'hF, ""); send(4'h0, 4'hF, "");
      send(4'h5, 4'h0, "R4 read at FF");
      send(4'h4, 4'h0, "R4 wrapped to id");

      // R1 unknown opcodes
      drain();
      send(4'h6, 4'h1, ""); send(4'h7, 4'h2, ""); send(4'hF, 4'hF, ""); send(4'hA, 4'h0, "");
      repeat (3) @(negedge clk);
      check("R1 no response", {7'd0, rsp_valid}, 8'h00);
      check("R1 mode unchanged", mode_out, 8'h3C);
      send(4'h4, 4'h0, "R1 address unchanged");

      // R9 back-pressure
      drain();
      hold = 1'b1;
      @(negedge clk);
      for (int i = 0; i < DEPTH; i++) send(4'h4, 4'h0, "R9 queued order");
      check("R9 stall when full", {7'd0, cmd_ready}, 8'h00);
      check("R9 valid when full", {7'd0, rsp_valid}, 8'h01);
      hold = 1'b0;
      drain();

      // random mix, R4/R9 ordering under throttled ready
      rnd_rdy = 1'b1;
      for (int n = 0; n < 500; n++) begin
         logic [3:0] op, nib;
         op  = 4'($urandom % 8);
         nib = 4'($urandom);
         if (op == 4'h1) nib = (nib[1:0] == 2'd0) ? 4'h0 : (nib[1:0] == 2'd1) ? 4'h1 : nib;
         if (n % 50 == 0) begin
            drain();
            status_in = 8'($urandom); trig_pos = 24'($urandom); stop_pos = 24'($urandom);
         end
         send(op, nib, "R4 random read");
         if (op == 4'h3) check("R7 mode_out random", mode_out, m_mode);
      end
      drain();
      rnd_rdy = 1'b0;
      repeat (4) @(negedge clk);
      check("R9 queue empty at end", 8'(exp_q.size()), 8'h00);
      summary();
   end
endmodule